// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept. For each frame an upstream parser presents three fields together with a one-cycle start strobe: the 48-bit destination address, the 16-bit type field and the 16-bit tag control word. Exactly two clock cycles later the block pulses a verdict. The verdict carries an accept flag, a reason code and, for exact hits, the index of the matching address entry.

The filter can accept a frame in four ways. A promiscuous override for the frame's address class accepts it at once. If no override applies, an exact match against one of sixteen programmable addresses accepts it. Failing that, a hit in a 4096-bit inexact hash table accepts it. A VLAN gate is applied separately. When the frame is tagged and VLAN filtering is enabled, the frame is dropped unless its VLAN ID is marked in a 4096-bit permit bitmap, whatever the address stage decided.

All settings are loaded through a single-cycle word write port. Each frame is judged on the settings that were in place before its start strobe.

Top module: `rxf_addr_filter`

## Requirements
- R1: While reset is high and after it is released, `vrd_valid` is low and every setting is cleared: control word zero, all exact entries invalid, both bitmaps zero, and the VLAN type register 16'h8100. With these defaults a broadcast frame is rejected.
- R2: Every cycle with `frm_start` high produces exactly one cycle of `vrd_valid` two clock edges later, and no other cycle has `vrd_valid` high. Starts on consecutive cycles each get their own verdict, in order.
- R3: The control word is at address 9'h000. Bit 0 is broadcast accept, bit 1 multicast promiscuous, bit 2 unicast promiscuous, bit 3 VLAN filter enable, and bits 5:4 are the hash window select. A destination of all ones is broadcast. Any other destination with bit 0 set (the group bit of byte 0) is multicast. Everything else is unicast. If the enable for the frame's class is set, the frame is accepted with kind 1. Broadcast frames are governed only by bit 0.
- R4: Destination byte i is on `frm_dst[8i+7:8i]`. Entry e has its low word at address 9'h020+2e and its high word at 9'h021+2e. The low word holds bytes 0..3, with byte i in bits 8i+7:8i. The high word holds byte 4 in bits 7:0, byte 5 in bits 15:8 and the valid flag in bit 31. A hit gives accept with kind 2 and `vrd_index`=e. When several entries hit, the lowest index wins.
- R5: An entry whose valid flag is clear never matches, even when its stored address equals the destination.
- R6: The hash key is {byte5,byte4} shifted right by 4, 3, 2 or 0 for window select 0, 1, 2 or 3, keeping the low 12 bits. Hash word k is at address 9'h080+k. The key selects word key[11:5] and bit key[4:0]. A set bit gives accept with kind 3. This applies to every address class.
- R7: A frame with no override, no exact hit and no hash hit gets `vrd_accept`=0, kind 0 and index 0.
- R8: A frame is tagged when `frm_type` equals the VLAN type register (address 9'h001, bits 15:0). If filter enable is set and the frame is tagged, VID = `frm_tci[11:0]`. The VID is checked against word VID[11:5] (address 9'h100+VID[11:5]), bit VID[4:0]. If that bit is clear, the frame is rejected with kind 0 regardless of the address result. Untagged frames, and all frames while filtering is disabled, pass the gate.
- R9: A write in the same cycle as a frame's start is not seen by that frame but is seen by the next one. A write in the cycle after the start does not change that frame's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 9 | Setting word address |
| cfg_wdata | input | 32 | Setting write data |
| frm_start | input | 1 | Frame fields valid, one cycle per frame |
| frm_dst | input | 48 | Destination address, byte i in bits 8i+7:8i |
| frm_type | input | 16 | Type field as a numeric value |
| frm_tci | input | 16 | Tag control word, VID in bits 11:0 |
| vrd_valid | output | 1 | Verdict strobe |
| vrd_accept | output | 1 | 1 = keep frame |
| vrd_kind | output | 2 | 0 reject, 1 override, 2 exact, 3 hash |
| vrd_index | output | 4 | Exact entry index, 0 otherwise |

## Verification
The following are checked on every cycle by the embedded properties:
- the fixed two-cycle spacing between start strobe and verdict;
- that an exact-kind verdict is always an accept;
- that a broadcast frame with its override set, and no VLAN gate, is accepted;
- that a reported exact hit points at a valid entry holding the frame's address;
- that a control write lands in the next cycle.

The following can only be shown by the bench's scenarios, because they depend on chosen table contents and write timing:
- the bit positions of the stored entries and bitmaps;
- the shift for each of the four hash windows;
- lowest-index priority;
- the VLAN veto over promiscuous accepts;
- write-versus-frame ordering.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_W     = 48;
    localparam int ENTRY_CNT = 16;
    localparam int HKEY_W    = 12;
    localparam int VID_W     = 12;
    localparam int WORD_W    = 32;
    localparam int CFG_AW    = 9;

    localparam logic [CFG_AW-1:0] ADDR_CTRL  = 9'h000;
    localparam logic [CFG_AW-1:0] ADDR_VTYPE = 9'h001;
    localparam logic [CFG_AW-1:0] ENTRY_BASE = 9'h020;
    localparam logic [CFG_AW-1:0] HASH_BASE  = 9'h080;
    localparam logic [CFG_AW-1:0] VLAN_BASE  = 9'h100;
    localparam logic [15:0]       VTYPE_RST  = 16'h8100;

    typedef enum logic [1:0] {
        KIND_REJECT  = 2'd0,
        KIND_PROMISC = 2'd1,
        KIND_EXACT   = 2'd2,
        KIND_HASH    = 2'd3
    } vkind_e;

    typedef enum logic [1:0] {
        DST_UCAST = 2'd0,
        DST_MCAST = 2'd1,
        DST_BCAST = 2'd2
    } dst_class_e;

    // Packed so that the field order gives the control word bit layout.
    typedef struct packed {
        logic [1:0] hash_sel;
        logic       vlan_en;
        logic       uc_promisc;
        logic       mc_promisc;
        logic       bc_accept;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [MAC_W-1:0] mac;
    } entry_t;

    function automatic dst_class_e classify(input logic [MAC_W-1:0] d);
        if (&d)
            return DST_BCAST;
        else if (d[0])
            return DST_MCAST;
        else
            return DST_UCAST;
    endfunction

    function automatic logic [HKEY_W-1:0] hash_key(input logic [MAC_W-1:0] d,
                                                   input logic [1:0] sel);
        logic [15:0] raw;
        logic [15:0] sh;
        raw = d[47:32];
        case (sel)
            2'd0:    sh = raw >> 4;
            2'd1:    sh = raw >> 3;
            2'd2:    sh = raw >> 2;
            default: sh = raw;
        endcase
        return sh[HKEY_W-1:0];
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int ENTRIES = ENTRY_CNT,
    parameter int KEY_W   = HKEY_W,
    parameter int VIDW    = VID_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [WORD_W-1:0]         cfg_wdata,
    output ctrl_t                     ctrl,
    output logic [15:0]               vtype,
    output entry_t [ENTRIES-1:0]      entries,
    input  logic [KEY_W-1:0]          hkey,
    output logic                      hash_bit,
    input  logic [VIDW-1:0]           vid,
    output logic                      vlan_bit
);
    localparam int HWORDS = (2 ** KEY_W) / WORD_W;
    localparam int VWORDS = (2 ** VIDW) / WORD_W;
    localparam int HSEL_W = KEY_W - 5;
    localparam int VSEL_W = VIDW - 5;
    localparam int EIDX_W = $clog2(ENTRIES);
    localparam logic [CFG_AW-1:0] ENTRY_END = CFG_AW'(ENTRY_BASE + 2 * ENTRIES);
    localparam logic [CFG_AW-1:0] HASH_END  = CFG_AW'(HASH_BASE + HWORDS);
    localparam logic [CFG_AW-1:0] VLAN_END  = CFG_AW'(VLAN_BASE + VWORDS);

    logic [WORD_W-1:0] hash_tbl [HWORDS];
    logic [WORD_W-1:0] vlan_tbl [VWORDS];

    logic [CFG_AW-1:0] ent_off, hash_off, vlan_off;
    logic              in_ent, in_hash, in_vlan;
    logic [EIDX_W-1:0] ent_sel;

    always_comb begin
        ent_off  = cfg_addr - ENTRY_BASE;
        hash_off = cfg_addr - HASH_BASE;
        vlan_off = cfg_addr - VLAN_BASE;
        in_ent   = (cfg_addr >= ENTRY_BASE) && (cfg_addr < ENTRY_END);
        in_hash  = (cfg_addr >= HASH_BASE) && (cfg_addr < HASH_END);
        in_vlan  = (cfg_addr >= VLAN_BASE) && (cfg_addr < VLAN_END);
        ent_sel  = ent_off[EIDX_W:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            vtype   <= VTYPE_RST;
            entries <= '0;
            for (int i = 0; i < HWORDS; i++) hash_tbl[i] <= '0;
            for (int i = 0; i < VWORDS; i++) vlan_tbl[i] <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_CTRL)
                ctrl <= ctrl_t'(cfg_wdata[$bits(ctrl_t)-1:0]);
            if (cfg_addr == ADDR_VTYPE)
                vtype <= cfg_wdata[15:0];
            if (in_ent) begin
                if (!ent_off[0]) begin
                    entries[ent_sel].mac[31:0] <= cfg_wdata;
                end else begin
                    entries[ent_sel].mac[47:32] <= cfg_wdata[15:0];
                    entries[ent_sel].valid      <= cfg_wdata[31];
                end
            end
            if (in_hash)
                hash_tbl[hash_off[HSEL_W-1:0]] <= cfg_wdata;
            if (in_vlan)
                vlan_tbl[vlan_off[VSEL_W-1:0]] <= cfg_wdata;
        end
    end

    always_comb begin
        hash_bit = hash_tbl[hkey[KEY_W-1:5]][hkey[4:0]];
        vlan_bit = vlan_tbl[vid[VIDW-1:5]][vid[4:0]];
    end

    // R3: a control write is visible in the following cycle
    p_ctrl_write_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_CTRL) |=>
            (ctrl == $past(cfg_wdata[$bits(ctrl_t)-1:0])));

endmodule

// File: rtl/rxf_exact_cam.sv
module rxf_exact_cam
    import rxf_pkg::*;
#(
    parameter int ENTRIES = ENTRY_CNT
) (
    input  entry_t [ENTRIES-1:0]          tbl,
    input  logic [MAC_W-1:0]              dst,
    output logic                          hit,
    output logic [$clog2(ENTRIES)-1:0]    idx
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq[g] = tbl[g].valid && (tbl[g].mac == dst);
        end
    endgenerate

    // lowest index has priority
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (eq[i]) idx = IW'(i);
        hit = |eq;
    end

    // R5: a reported hit refers to a valid entry holding this address
    always_comb begin
        if (hit)
            p_hit_entry_valid_r5: assert (tbl[idx].valid && tbl[idx].mac == dst);
    end

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
    import rxf_pkg::*;
#(
    parameter int ENTRIES = ENTRY_CNT,
    parameter int KEY_W   = HKEY_W,
    parameter int VIDW    = VID_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]            cfg_wdata,
    input  logic                         frm_start,
    input  logic [MAC_W-1:0]             frm_dst,
    input  logic [15:0]                  frm_type,
    input  logic [15:0]                  frm_tci,
    output logic                         vrd_valid,
    output logic                         vrd_accept,
    output logic [1:0]                   vrd_kind,
    output logic [$clog2(ENTRIES)-1:0]   vrd_index
);
    localparam int IW = $clog2(ENTRIES);

    ctrl_t                cfg_ctrl;
    logic [15:0]          cfg_vtype;
    entry_t [ENTRIES-1:0] cfg_entries;
    logic [KEY_W-1:0]     key;
    logic                 hash_bit, vlan_bit;
    logic                 cam_hit;
    logic [IW-1:0]        cam_idx;

    rxf_cfg_regs #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .VIDW(VIDW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ctrl     (cfg_ctrl),
        .vtype    (cfg_vtype),
        .entries  (cfg_entries),
        .hkey     (key),
        .hash_bit (hash_bit),
        .vid      (frm_tci[VIDW-1:0]),
        .vlan_bit (vlan_bit)
    );

    rxf_exact_cam #(.ENTRIES(ENTRIES)) u_cam (
        .tbl(cfg_entries),
        .dst(frm_dst),
        .hit(cam_hit),
        .idx(cam_idx)
    );

    // Stage 1: every setting-dependent decision is taken on the strobe cycle
    logic promisc_now, vlan_ok_now;

    always_comb begin
        key = hash_key(frm_dst, cfg_ctrl.hash_sel);
        case (classify(frm_dst))
            DST_BCAST: promisc_now = cfg_ctrl.bc_accept;
            DST_MCAST: promisc_now = cfg_ctrl.mc_promisc;
            default:   promisc_now = cfg_ctrl.uc_promisc;
        endcase
        vlan_ok_now = !(cfg_ctrl.vlan_en && frm_type == cfg_vtype) || vlan_bit;
    end

    logic          s1_valid, s1_promisc, s1_exact, s1_hash, s1_vlan_ok;
    logic [IW-1:0] s1_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_promisc <= 1'b0;
            s1_exact   <= 1'b0;
            s1_hash    <= 1'b0;
            s1_vlan_ok <= 1'b0;
            s1_idx     <= '0;
        end else begin
            s1_valid   <= frm_start;
            s1_promisc <= frm_start && promisc_now;
            s1_exact   <= frm_start && cam_hit;
            s1_hash    <= frm_start && hash_bit;
            s1_vlan_ok <= vlan_ok_now;
            s1_idx     <= cam_idx;
        end
    end

    // Stage 2: combine into the verdict
    vkind_e        kind_n;
    logic          accept_n;
    logic [IW-1:0] index_n;

    always_comb begin
        accept_n = s1_vlan_ok && (s1_promisc || s1_exact || s1_hash);
        if (!s1_vlan_ok)     kind_n = KIND_REJECT;
        else if (s1_promisc) kind_n = KIND_PROMISC;
        else if (s1_exact)   kind_n = KIND_EXACT;
        else if (s1_hash)    kind_n = KIND_HASH;
        else                 kind_n = KIND_REJECT;
        index_n = (kind_n == KIND_EXACT) ? s1_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vrd_valid  <= 1'b0;
            vrd_accept <= 1'b0;
            vrd_kind   <= KIND_REJECT;
            vrd_index  <= '0;
        end else begin
            vrd_valid  <= s1_valid;
            vrd_accept <= s1_valid && accept_n;
            vrd_kind   <= s1_valid ? kind_n : KIND_REJECT;
            vrd_index  <= s1_valid ? index_n : '0;
        end
    end

    // R2: each strobe yields a verdict two edges later
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        frm_start |-> ##2 vrd_valid);

    // R2: no verdict without a strobe
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !frm_start |-> ##2 !vrd_valid);

    // R4: an exact-kind verdict is always an accept
    p_exact_accepts_r4: assert property (@(posedge clk) disable iff (rst)
        (vrd_valid && vrd_kind == KIND_EXACT) |-> vrd_accept);

    // R3: broadcast with its override and no VLAN gate is accepted as override
    p_bcast_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_start && (&frm_dst) && cfg_ctrl.bc_accept && !cfg_ctrl.vlan_en)
            |-> ##2 (vrd_accept && vrd_kind == KIND_PROMISC));

endmodule

// File: tb/rxf_addr_filter_test.sv
`timescale 1ns/1ps
module rxf_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frm_start = 1'b0;
    logic [47:0] frm_dst = '0;
    logic [15:0] frm_type = '0;
    logic [15:0] frm_tci = '0;
    logic        vrd_valid, vrd_accept;
    logic [1:0]  vrd_kind;
    logic [3:0]  vrd_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxf_addr_filter uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frm_start(frm_start), .frm_dst(frm_dst), .frm_type(frm_type),
        .frm_tci(frm_tci),
        .vrd_valid(vrd_valid), .vrd_accept(vrd_accept),
        .vrd_kind(vrd_kind), .vrd_index(vrd_index)
    );

    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] typ;
        logic [15:0] tci;
        logic        acc;
        logic [1:0]  kind;
        logic [3:0]  idx;
        logic [3:0]  req;
    } vec_t;

    localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] A3  = 48'h554433221102;
    localparam logic [47:0] A5  = 48'hEEDDCCBBAA02;
    localparam logic [47:0] UNK = 48'h010203040506;

    localparam vec_t VECS [12] = '{
        '{BC,                16'h0800, 16'h0000, 1'b1, 2'd1, 4'd0, 4'd3},  // R3
        '{A3,                16'h0800, 16'h0000, 1'b1, 2'd2, 4'd3, 4'd4},  // R4, R5
        '{A5,                16'h0800, 16'h0000, 1'b1, 2'd2, 4'd5, 4'd4},  // R4 lowest wins
        '{48'h3412005E0001,  16'h0800, 16'h0000, 1'b1, 2'd3, 4'd0, 4'd6},  // R6
        '{48'h3412005E0003,  16'h0800, 16'h0000, 1'b1, 2'd3, 4'd0, 4'd6},  // R6
        '{48'h3422005E0001,  16'h0800, 16'h0000, 1'b0, 2'd0, 4'd0, 4'd7},  // R7
        '{UNK,               16'h0800, 16'h0000, 1'b0, 2'd0, 4'd0, 4'd7},  // R7
        '{A3,                16'h8100, 16'h0064, 1'b1, 2'd2, 4'd3, 4'd8},  // R8
        '{A3,                16'h8100, 16'h0065, 1'b0, 2'd0, 4'd0, 4'd8},  // R8
        '{A3,                16'h8100, 16'hE064, 1'b1, 2'd2, 4'd3, 4'd8},  // R8
        '{BC,                16'h88A8, 16'h0065, 1'b1, 2'd1, 4'd0, 4'd8},  // R8
        '{BC,                16'h8100, 16'h0065, 1'b0, 2'd0, 4'd0, 4'd8}   // R8
    };

    task automatic check_verdict(input string req, input logic acc,
                                 input logic [1:0] kind, input logic [3:0] idx);
        checks++;
        if (vrd_valid !== 1'b1 || vrd_accept !== acc || vrd_kind !== kind ||
            vrd_index !== idx) begin
            errors++;
            $display("FAIL %s: got valid=%0d acc=%0d kind=%0d idx=%0d exp valid=1 acc=%0d kind=%0d idx=%0d",
                     req, vrd_valid, vrd_accept, vrd_kind, vrd_index, acc, kind, idx);
        end
    endtask

    task automatic check_idle(input string req);
        checks++;
        if (vrd_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: got valid=%0d exp valid=0", req, vrd_valid);
        end
    endtask

    task automatic cfg_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_frame(input logic [47:0] d, input logic [15:0] t,
                               input logic [15:0] c);
        frm_start = 1'b1; frm_dst = d; frm_type = t; frm_tci = c;
    endtask

    // leaves the bench at the negedge where the verdict is visible
    task automatic send(input logic [47:0] d, input logic [15:0] t,
                        input logic [15:0] c);
        @(negedge clk);
        drive_frame(d, t, c);
        @(negedge clk);
        frm_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: verdict strobe stays low through reset
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");
        send(BC, 16'h0800, 16'h0);
        check_verdict("R1 defaults reject broadcast", 1'b0, 2'd0, 4'd0);

        // common settings: broadcast accept + VLAN filtering, window 0
        cfg_write(9'h000, 32'h0000_0009);
        cfg_write(9'h020, 32'h3322_1102);     // entry 0 same address, invalid
        cfg_write(9'h021, 32'h0000_5544);
        cfg_write(9'h026, 32'h3322_1102);     // entry 3
        cfg_write(9'h027, 32'h8000_5544);
        cfg_write(9'h02A, 32'hCCBB_AA02);     // entry 5
        cfg_write(9'h02B, 32'h8000_EEDD);
        cfg_write(9'h02E, 32'hCCBB_AA02);     // entry 7 duplicate of 5
        cfg_write(9'h02F, 32'h8000_EEDD);
        cfg_write(9'h09A, 32'h0000_0002);     // hash word 26 bit 1
        cfg_write(9'h103, 32'h0000_0010);     // VID 100

        for (int i = 0; i < 12; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
            send(VECS[i].dst, VECS[i].typ, VECS[i].tci);
            check_verdict(tag, VECS[i].acc, VECS[i].kind, VECS[i].idx);
        end

        // R2: single-cycle pulse and back-to-back strobes
        @(negedge clk);
        drive_frame(BC, 16'h0800, 16'h0);
        @(negedge clk);
        drive_frame(A3, 16'h0800, 16'h0);
        @(negedge clk);
        frm_start = 1'b0;
        check_verdict("R2 first of pair", 1'b1, 2'd1, 4'd0);
        @(negedge clk);
        check_verdict("R2 second of pair", 1'b1, 2'd2, 4'd3);
        @(negedge clk);
        check_idle("R2 pulse ends");

        // R6: the four hash windows on key source 16'h1234
        cfg_write(9'h092, 32'h0000_0040);     // word 18 bit 6 (window 1)
        cfg_write(9'h000, 32'h0000_0010);
        send(48'h123400000000, 16'h0800, 16'h0);
        check_verdict("R6 window 1 hit", 1'b1, 2'd3, 4'd0);
        cfg_write(9'h000, 32'h0000_0020);
        send(48'h123400000000, 16'h0800, 16'h0);
        check_verdict("R6 window 2 miss", 1'b0, 2'd0, 4'd0);
        cfg_write(9'h000, 32'h0000_0030);
        send(48'h123400000000, 16'h0800, 16'h0);
        check_verdict("R6 window 3 miss", 1'b0, 2'd0, 4'd0);
        cfg_write(9'h000, 32'h0000_0000);
        send(48'h123400000000, 16'h0800, 16'h0);
        check_verdict("R6 window 0 miss", 1'b0, 2'd0, 4'd0);
        cfg_write(9'h0A4, 32'h0000_2000);     // word 36 bit 13 (window 2)
        cfg_write(9'h000, 32'h0000_0020);
        send(48'h123400000000, 16'h0800, 16'h0);
        check_verdict("R6 window 2 hit", 1'b1, 2'd3, 4'd0);
        cfg_write(9'h091, 32'h0010_0000);     // word 17 bit 20 (window 3)
        cfg_write(9'h000, 32'h0000_0030);
        send(48'h123400000000, 16'h0800, 16'h0);
        check_verdict("R6 window 3 hit", 1'b1, 2'd3, 4'd0);

        // R3: class-specific overrides
        cfg_write(9'h000, 32'h0000_0002);
        send(48'h3422005E0001, 16'h0800, 16'h0);
        check_verdict("R3 multicast override", 1'b1, 2'd1, 4'd0);
        send(BC, 16'h0800, 16'h0);
        check_verdict("R3 broadcast ignores multicast override", 1'b0, 2'd0, 4'd0);
        cfg_write(9'h000, 32'h0000_0004);
        send(UNK, 16'h0800, 16'h0);
        check_verdict("R3 unicast override", 1'b1, 2'd1, 4'd0);
        send(48'h3422005E0001, 16'h0800, 16'h0);
        check_verdict("R3 multicast ignores unicast override", 1'b0, 2'd0, 4'd0);

        // R5: invalidate entry 3, its address no longer matches
        cfg_write(9'h000, 32'h0000_0000);
        cfg_write(9'h027, 32'h0000_5544);
        send(A3, 16'h0800, 16'h0);
        check_verdict("R5 invalid entry skipped", 1'b0, 2'd0, 4'd0);

        // R9: write in the strobe cycle is not seen by that frame
        @(negedge clk);
        drive_frame(UNK, 16'h0800, 16'h0);
        cfg_we = 1'b1; cfg_addr = 9'h000; cfg_wdata = 32'h0000_0004;
        @(negedge clk);
        frm_start = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        check_verdict("R9 same-cycle write not seen", 1'b0, 2'd0, 4'd0);
        send(UNK, 16'h0800, 16'h0);
        check_verdict("R9 write seen by next frame", 1'b1, 2'd1, 4'd0);
        // R9: write during evaluation does not disturb the verdict
        @(negedge clk);
        drive_frame(UNK, 16'h0800, 16'h0);
        @(negedge clk);
        frm_start = 1'b0;
        cfg_we = 1'b1; cfg_addr = 9'h000; cfg_wdata = 32'h0000_0000;
        @(negedge clk);
        cfg_we = 1'b0;
        check_verdict("R9 mid-evaluation write ignored", 1'b1, 2'd1, 4'd0);
        send(UNK, 16'h0800, 16'h0);
        check_verdict("R9 later frame sees write", 1'b0, 2'd0, 4'd0);

        // R8: programmable tag type
        cfg_write(9'h000, 32'h0000_000D);
        cfg_write(9'h001, 32'h0000_88A8);
        send(BC, 16'h88A8, 16'h0065);
        check_verdict("R8 new tag type gated", 1'b0, 2'd0, 4'd0);
        send(BC, 16'h8100, 16'h0065);
        check_verdict("R8 old tag type untagged", 1'b1, 2'd1, 4'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule